// File: doc/BRIEF.md
# Immediate-Operand Execute Unit

This block is the execute stage for instructions that carry a 16-bit immediate operand. Each cycle it takes an already decoded operation code, a 32-bit register operand and the 16-bit immediate. It computes one of six results: a signed add that detects overflow, an add that never traps, a signed compare, an unsigned compare, a bitwise OR, or a load of the immediate into the upper half of the word. A single register stage holds the result, a write-enable for the destination register and an overflow exception flag. All three appear one clock after the instruction is presented.

Both adds and both compares sign-extend the immediate, including the unsigned forms. The OR zero-extends it. The upper-half load clears the low sixteen bits. A full 32-bit constant can therefore be built with an upper-half load followed by an OR of the low half. The register file, memory access and the splitting of large constants into instruction pairs are handled elsewhere.

Top module: `imm_exec_unit`

## Requirements
- R1: A synchronous active-high `rst` clears `out_result` to 0 and drops `out_wen` and `out_ovf` on the next clock edge.
- R2: Op code 0 (signed add) registers `in_rs` plus the sign-extended immediate, wrapped to 32 bits, one clock later. When both operands have the same sign and the sum has the other sign, `out_ovf` is 1 and `out_wen` is 0. Otherwise `out_ovf` is 0 and `out_wen` is 1.
- R3: Op code 1 (unchecked add) registers the same wrapped sum with the immediate sign-extended. `out_ovf` is always 0 and `out_wen` is always 1.
- R4: Op code 2 (signed compare) registers 32'd1 when `in_rs` is less than the sign-extended immediate as signed numbers, and 32'd0 otherwise, with `out_wen` 1.
- R5: Op code 3 (unsigned compare) sign-extends the immediate first. It then registers 32'd1 when `in_rs` is below that value as unsigned numbers, and 32'd0 otherwise.
- R6: Op code 4 (OR) registers `in_rs` OR'd with the zero-extended immediate, with `out_wen` 1.
- R7: Op code 5 (upper load) registers the immediate in bits 31..16 and zeros in bits 15..0, with `out_wen` 1.
- R8: An upper load of the high half, followed by an OR of the low half applied to that result, reproduces any 32-bit constant, e.g. 0xABABCDCD.
- R9: While `in_valid` is 0, `out_wen` and `out_ovf` go to 0 on the next edge and `out_result` keeps its value.
- R10: Op codes 6 and 7 are undefined. With `in_valid` 1 they act like an idle cycle: both flags go to 0 and `out_result` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| in_op | input | 3 | Decoded operation code |
| in_rs | input | 32 | Register operand |
| in_imm | input | 16 | Immediate field |
| out_result | output | 32 | Registered result |
| out_wen | output | 1 | Registered destination write-enable |
| out_ovf | output | 1 | Registered overflow exception |

## Verification
The embedded properties check several rules on every cycle. The overflow flag and the write-enable are never high together. The unchecked add never traps. Compare results only ever take the values 0 or 1. An upper load always leaves a zero low half. Idle and undefined cycles keep the result and drop both flags. For same-sign signed adds, the flag matches the sign change of the sum. The scoreboard scenarios supply the exact numbers, which the properties cannot see. These include the sum and compare values at the sign boundaries, the unsigned compare against a sign-extended 0xFFFF, the zero extension of 0x8000 in the OR, the two-step constant build, and a reset in the middle of a run.

// File: rtl/imm_exec_unit.sv
module imm_exec_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [DATA_W-1:0] in_rs,
  input  logic [IMM_W-1:0]  in_imm,
  output logic [DATA_W-1:0] out_result,
  output logic              out_wen,
  output logic              out_ovf
);
  localparam int EXT_W = DATA_W - IMM_W;
  localparam logic [2:0] OP_ADD  = 3'd0;
  localparam logic [2:0] OP_ADDU = 3'd1;
  localparam logic [2:0] OP_SLT  = 3'd2;
  localparam logic [2:0] OP_SLTU = 3'd3;
  localparam logic [2:0] OP_OR   = 3'd4;
  localparam logic [2:0] OP_LUI  = 3'd5;

  logic [DATA_W-1:0] imm_sx, imm_zx, sum, res_d;
  logic add_ovf, trap, known_op;

  assign imm_sx   = {{EXT_W{in_imm[IMM_W-1]}}, in_imm};
  assign imm_zx   = {{EXT_W{1'b0}}, in_imm};
  assign sum      = in_rs + imm_sx;
  assign add_ovf  = (in_rs[DATA_W-1] == imm_sx[DATA_W-1]) && (sum[DATA_W-1] != in_rs[DATA_W-1]);
  assign known_op = (in_op <= OP_LUI);
  assign trap     = (in_op == OP_ADD) && add_ovf;

  always_comb begin
    case (in_op)
      OP_ADD, OP_ADDU: res_d = sum;
      OP_SLT:  res_d = {{(DATA_W-1){1'b0}}, ($signed(in_rs) < $signed(imm_sx))};
      OP_SLTU: res_d = {{(DATA_W-1){1'b0}}, (in_rs < imm_sx)};
      OP_OR:   res_d = in_rs | imm_zx;
      OP_LUI:  res_d = {in_imm, {EXT_W{1'b0}}};
      default: res_d = out_result;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_result <= '0;
      out_wen    <= 1'b0;
      out_ovf    <= 1'b0;
    end else if (in_valid && known_op) begin
      out_result <= res_d;
      out_wen    <= !trap;
      out_ovf    <= trap;
    end else begin
      out_wen    <= 1'b0;
      out_ovf    <= 1'b0;
    end
  end

  // R2
  ovf_blocks_write_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_ovf && out_wen));

  // R2
  signed_add_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADD && in_rs[DATA_W-1] == in_imm[IMM_W-1])
      |=> (out_ovf == (out_result[DATA_W-1] != $past(in_rs[DATA_W-1]))));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_ADDU) |=> (!out_ovf && out_wen));

  // R4 R5
  cmp_is_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_op == OP_SLT || in_op == OP_SLTU)) |=> (out_result[DATA_W-1:1] == '0));

  // R7
  upper_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op == OP_LUI) |=> (out_result[EXT_W-1:0] == '0 && out_wen));

  // R9 R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || in_op > OP_LUI) |=> ($stable(out_result) && !out_wen && !out_ovf));
endmodule

// File: tb/imm_exec_unit_tb_top.sv
module imm_exec_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = 3'd0;
  logic [31:0] in_rs = 32'd0;
  logic [15:0] in_imm = 16'd0;
  logic [31:0] out_result;
  logic        out_wen, out_ovf;

  typedef struct packed {
    logic [31:0] res;
    logic        wen;
    logic        ovf;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;
  logic [31:0] model_res = 32'd0;

  imm_exec_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_rs(in_rs), .in_imm(in_imm),
    .out_result(out_result), .out_wen(out_wen), .out_ovf(out_ovf)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic drive(input bit r, input bit v, input logic [2:0] op,
                       input logic [31:0] rs, input logic [15:0] imm, input string tag);
    exp_t e;
    logic [31:0] sx, s;
    @(negedge clk);
    rst = r; in_valid = v; in_op = op; in_rs = rs; in_imm = imm;
    sx = {{16{imm[15]}}, imm};
    s  = rs + sx;
    e.wen = 1'b0; e.ovf = 1'b0; e.res = model_res;
    if (r) begin
      e.res = 32'd0;
    end else if (v && op <= 3'd5) begin
      e.wen = 1'b1;
      case (op)
        3'd0: begin
          e.res = s;
          if (rs[31] == sx[31] && s[31] != rs[31]) begin e.ovf = 1'b1; e.wen = 1'b0; end
        end
        3'd1: e.res = s;
        3'd2: e.res = ($signed(rs) < $signed(sx)) ? 32'd1 : 32'd0;
        3'd3: e.res = (rs < sx) ? 32'd1 : 32'd0;
        3'd4: e.res = rs | {16'h0, imm};
        default: e.res = {imm, 16'h0};
      endcase
    end
    model_res = e.res;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      exp_t e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (out_result !== e.res || out_wen !== e.wen || out_ovf !== e.ovf) begin
        failures++;
        $display("FAIL %s: got res=%h wen=%b ovf=%b, expected res=%h wen=%b ovf=%b",
                 t, out_result, out_wen, out_ovf, e.res, e.wen, e.ovf);
      end
    end
  end

  initial begin
    drive(1, 0, 3'd0, 32'd0, 16'd0, "R1 reset");
    drive(0, 1, 3'd0, 32'd100, 16'd23, "R2 add small");
    drive(0, 1, 3'd0, 32'h7FFF_FFFF, 16'd1, "R2 add positive overflow");
    drive(0, 1, 3'd0, 32'h8000_0000, 16'hFFFF, "R2 add negative overflow");
    drive(0, 1, 3'd0, 32'd5, 16'hFFFE, "R2 add negative immediate");
    drive(0, 1, 3'd1, 32'h7FFF_FFFF, 16'd1, "R3 unchecked add wraps");
    drive(0, 1, 3'd1, 32'd0, 16'h8000, "R3 unchecked add sign-extends");
    drive(0, 1, 3'd2, 32'hFFFF_FFFF, 16'd5, "R4 signed compare true");
    drive(0, 1, 3'd2, 32'd5, 16'hFFFF, "R4 signed compare false");
    drive(0, 1, 3'd3, 32'd5, 16'hFFFF, "R5 unsigned compare vs extended");
    drive(0, 1, 3'd3, 32'hFFFF_FFFF, 16'hFFFF, "R5 unsigned compare equal");
    drive(0, 1, 3'd4, 32'h1234_0000, 16'h8000, "R6 or zero-extend");
    drive(0, 1, 3'd5, 32'hDEAD_BEEF, 16'hABAB, "R7 upper load");
    drive(0, 1, 3'd4, 32'hABAB_0000, 16'hCDCD, "R8 build constant");
    drive(0, 0, 3'd5, 32'h1, 16'h1111, "R9 idle holds");
    drive(0, 1, 3'd6, 32'h1, 16'h2222, "R10 undefined op 6");
    drive(0, 1, 3'd7, 32'h1, 16'h3333, "R10 undefined op 7");
    drive(0, 1, 3'd5, 32'h0, 16'h0001, "R7 upper load small");
    drive(1, 1, 3'd1, 32'd9, 16'd9, "R1 reset mid-run");
    drive(0, 0, 3'd0, 32'd0, 16'd0, "R9 idle after reset");
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*5000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule